// File: doc/BRIEF.md
# eDRAM Line Vulnerability Accumulator

This block watches the event stream of a small eDRAM cache data array and keeps running totals of the bit-time during which stored data could be corrupted by a particle strike and the corruption would still escape. The tracked array has `LINES` lines of `W` bits each. For every line the block shadows the stored word, the time stamp of the most recent access and the number of refreshes seen since that access.

The two stored values are charged differently. A bit holding 1 is exposed for the whole interval between two accesses. A bit holding 0 is exposed only while a refresh is in progress, so it is charged `REF_DUR` cycles for each refresh inside the interval. An interval counts only when the event that closes it is a read or an eviction, because then a corrupted value could reach the processor or memory. When a write closes an interval, the overwrite hides any upset, so nothing is charged. The block also keeps a capacity-time total: valid lines times `W`, summed over every cycle. Software can later divide the combined total by the capacity-time total to get a vulnerability ratio.

Events arrive on a valid/ready stream, with at most one event per cycle. The block takes an event in any cycle where `ev_valid` and `ev_ready` are both high. `ev_ready` drops only in a cycle where `clr` is high. A producer that sees `ev_ready` low must hold its event and offer it again in the next cycle. The control pins `rst` and `clr` are plain level inputs.

Top module: `vuln_tally`

## Requirements
- R1: A read (op 1) or evict (op 3) taken on a valid line adds (number of 1 bits in the stored word) × (current time − time of that line's last access) to `tot_one`. Time advances by one every cycle.
- R2: The same read or evict adds (number of 0 bits) × (refreshes counted since the last access) × `REF_DUR` to `tot_zero`.
- R3: A write (op 2) on a valid line, or a fill (op 0) on any line, adds nothing to either total. The new word is stored, and later charges use that word.
- R4: A refresh (op 4) adds one to the refresh count of every valid line. The per-line count saturates at its maximum. A refresh never closes an interval and never changes a total. The line index of a refresh is ignored.
- R5: Every taken fill, read, write or evict on a line restarts that line's interval. Its time stamp becomes the current time and its refresh count becomes 0.
- R6: A fill makes a line valid and an evict makes it invalid. A read, write or evict on an invalid line is ignored completely: no charge, no change of state. Op codes 5 to 7 are also ignored.
- R7: `tot_sum` equals `tot_one + tot_zero`, saturated at the maximum value of `ACC_W` bits.
- R8: `cap_time` grows by (number of valid lines) × `W` every cycle.
- R9: Each total saturates at all ones and never wraps.
- R10: `clr` zeroes all totals, `cap_time` and the time counter, and invalidates all lines. `ev_ready` is low in every cycle where `clr` is high.
- R11: An event is taken only in a cycle where `ev_valid` and `ev_ready` are both high.
- R12: After `rst`, all totals are 0 and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of totals and line state |
| ev_valid | input | 1 | An event is offered |
| ev_ready | output | 1 | The block can take an event this cycle |
| ev_op | input | 3 | Event code: 0 fill, 1 read, 2 write, 3 evict, 4 refresh |
| ev_line | input | $clog2(LINES) | Line index |
| ev_wdata | input | W | Word stored by a fill or write |
| tot_one | output | ACC_W | Charge total for bits holding 1 |
| tot_zero | output | ACC_W | Charge total for bits holding 0 |
| tot_sum | output | ACC_W | Saturated sum of both charge totals |
| cap_time | output | ACC_W | Valid-bits × cycles total |

## Verification
A wrong shadow word, time stamp or refresh count stays hidden until the next read or evict on that line. That event adds a wrong amount to `tot_one` or `tot_zero`, visible on the following clock edge. A wrong valid bit shows up sooner: `cap_time` drifts by `W` in the very next cycle. The bench therefore mixes long random runs with many reads and evicts against a shadow model, and directed cases with hand-computed charges. A second instance with narrow totals drives every saturation path.

// File: rtl/vuln_pkg.sv
package vuln_pkg;
  typedef enum logic [2:0] {
    OP_FILL    = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_EVICT   = 3'd3,
    OP_REFRESH = 3'd4
  } op_e;
endpackage

// File: rtl/vt_sat_acc.sv
module vt_sat_acc #(
  parameter int ACC_W = 48,
  parameter int IN_W  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [IN_W-1:0]  inc,
  output logic [ACC_W-1:0] q
);
  localparam int EXT_W = (IN_W > ACC_W) ? IN_W : ACC_W;
  localparam int SW = EXT_W + 1;
  localparam logic [SW-1:0] LIM = SW'({ACC_W{1'b1}});

  logic [SW-1:0] sum;
  assign sum = SW'(q) + SW'(inc);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en) q <= (sum > LIM) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/vt_line_store.sv
module vt_line_store #(
  parameter int LINES = 8,
  parameter int W     = 16,
  parameter int TS_W  = 16,
  parameter int RC_W  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             touch,
  input  logic             load,
  input  logic             fill,
  input  logic             evict,
  input  logic             refresh,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic [TS_W-1:0]  now,
  output logic [LINES-1:0] valid_vec,
  output logic [W-1:0]     sel_data,
  output logic [TS_W-1:0]  sel_ts,
  output logic [RC_W-1:0]  sel_rc
);
  logic [W-1:0]    data_q [LINES];
  logic [TS_W-1:0] ts_q   [LINES];
  logic [RC_W-1:0] rc_q   [LINES];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_vec <= '0;
      for (int i = 0; i < LINES; i++) begin
        data_q[i] <= '0;
        ts_q[i]   <= '0;
        rc_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (touch && (idx == IDX_W'(i))) begin
          ts_q[i] <= now;
          rc_q[i] <= '0;
        end else if (refresh && valid_vec[i] && (rc_q[i] != {RC_W{1'b1}})) begin
          rc_q[i] <= rc_q[i] + 1'b1;
        end
        if (load && (idx == IDX_W'(i))) data_q[i] <= wdata;
        if (fill && (idx == IDX_W'(i)))       valid_vec[i] <= 1'b1;
        else if (evict && (idx == IDX_W'(i))) valid_vec[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    sel_data = '0;
    sel_ts   = '0;
    sel_rc   = '0;
    for (int i = 0; i < LINES; i++) begin
      if (idx == IDX_W'(i)) begin
        sel_data = data_q[i];
        sel_ts   = ts_q[i];
        sel_rc   = rc_q[i];
      end
    end
  end
endmodule

// File: rtl/vt_charge.sv
module vt_charge #(
  parameter int W       = 16,
  parameter int TS_W    = 16,
  parameter int RC_W    = 8,
  parameter int REF_DUR = 4,
  parameter int CNT_W   = $clog2(W + 1),
  parameter int DUR_W   = $clog2(REF_DUR + 1),
  parameter int P1_W    = CNT_W + TS_W,
  parameter int P0_W    = CNT_W + RC_W + DUR_W
) (
  input  logic [W-1:0]    word,
  input  logic [TS_W-1:0] now,
  input  logic [TS_W-1:0] opened,
  input  logic [RC_W-1:0] refreshes,
  output logic [P1_W-1:0] add_one,
  output logic [P0_W-1:0] add_zero
);
  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] zeros;
  logic [TS_W-1:0]  span;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CNT_W'(word[i]);
  end

  assign zeros    = CNT_W'(W) - ones;
  assign span     = now - opened;
  assign add_one  = P1_W'(ones) * P1_W'(span);
  assign add_zero = P0_W'(zeros) * P0_W'(refreshes) * P0_W'(REF_DUR);
endmodule

// File: rtl/vuln_tally.sv
module vuln_tally #(
  parameter int LINES   = 8,
  parameter int W       = 16,
  parameter int TS_W    = 16,
  parameter int RC_W    = 8,
  parameter int REF_DUR = 4,
  parameter int ACC_W   = 48,
  parameter int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [2:0]       ev_op,
  input  logic [IDX_W-1:0] ev_line,
  input  logic [W-1:0]     ev_wdata,
  output logic [ACC_W-1:0] tot_one,
  output logic [ACC_W-1:0] tot_zero,
  output logic [ACC_W-1:0] tot_sum,
  output logic [ACC_W-1:0] cap_time
);
  import vuln_pkg::*;

  localparam int CNT_W = $clog2(W + 1);
  localparam int DUR_W = $clog2(REF_DUR + 1);
  localparam int P1_W  = CNT_W + TS_W;
  localparam int P0_W  = CNT_W + RC_W + DUR_W;
  localparam int VC_W  = $clog2(LINES + 1);
  localparam int CI_W  = VC_W + CNT_W;

  logic             acc;
  logic             sel_valid;
  logic             is_fill, is_read, is_write, is_evict, is_refresh;
  logic             touch, load, charge;
  logic [TS_W-1:0]  now;
  logic [LINES-1:0] line_valid;
  logic [W-1:0]     sel_data;
  logic [TS_W-1:0]  sel_ts;
  logic [RC_W-1:0]  sel_rc;
  logic [P1_W-1:0]  add_one;
  logic [P0_W-1:0]  add_zero;
  logic [VC_W-1:0]  vcount;
  logic [CI_W-1:0]  cap_inc;
  logic [ACC_W:0]   sum_ext;

  assign ev_ready   = !clr;
  assign acc        = ev_valid && ev_ready;
  assign sel_valid  = line_valid[ev_line];
  assign is_fill    = (ev_op == OP_FILL);
  assign is_read    = (ev_op == OP_READ);
  assign is_write   = (ev_op == OP_WRITE);
  assign is_evict   = (ev_op == OP_EVICT);
  assign is_refresh = (ev_op == OP_REFRESH);

  assign charge = acc && sel_valid && (is_read || is_evict);
  assign touch  = acc && (is_fill || (sel_valid && (is_read || is_write || is_evict)));
  assign load   = acc && (is_fill || (sel_valid && is_write));

  always_ff @(posedge clk) begin
    if (rst || clr) now <= '0;
    else            now <= now + 1'b1;
  end

  vt_line_store #(
    .LINES(LINES), .W(W), .TS_W(TS_W), .RC_W(RC_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .clr(clr),
    .touch(touch), .load(load),
    .fill(acc && is_fill), .evict(charge && is_evict),
    .refresh(acc && is_refresh),
    .idx(ev_line), .wdata(ev_wdata), .now(now),
    .valid_vec(line_valid), .sel_data(sel_data),
    .sel_ts(sel_ts), .sel_rc(sel_rc)
  );

  vt_charge #(
    .W(W), .TS_W(TS_W), .RC_W(RC_W), .REF_DUR(REF_DUR)
  ) u_charge (
    .word(sel_data), .now(now), .opened(sel_ts), .refreshes(sel_rc),
    .add_one(add_one), .add_zero(add_zero)
  );

  vt_sat_acc #(.ACC_W(ACC_W), .IN_W(P1_W)) u_acc_one (
    .clk(clk), .rst(rst), .clr(clr), .en(charge), .inc(add_one), .q(tot_one)
  );

  vt_sat_acc #(.ACC_W(ACC_W), .IN_W(P0_W)) u_acc_zero (
    .clk(clk), .rst(rst), .clr(clr), .en(charge), .inc(add_zero), .q(tot_zero)
  );

  always_comb begin
    vcount = '0;
    for (int i = 0; i < LINES; i++) vcount = vcount + VC_W'(line_valid[i]);
  end
  assign cap_inc = CI_W'(vcount) * CI_W'(W);

  vt_sat_acc #(.ACC_W(ACC_W), .IN_W(CI_W)) u_acc_cap (
    .clk(clk), .rst(rst), .clr(clr), .en(1'b1), .inc(cap_inc), .q(cap_time)
  );

  assign sum_ext = {1'b0, tot_one} + {1'b0, tot_zero};
  assign tot_sum = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];
endmodule

// File: rtl/vuln_tally_chk.sv
module vuln_tally_chk #(
  parameter int LINES = 8,
  parameter int W     = 16,
  parameter int ACC_W = 48,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [2:0]       ev_op,
  input logic [IDX_W-1:0] ev_line,
  input logic [ACC_W-1:0] tot_one,
  input logic [ACC_W-1:0] tot_zero,
  input logic [ACC_W-1:0] tot_sum,
  input logic [ACC_W-1:0] cap_time,
  input logic [LINES-1:0] line_valid
);
  logic taken;
  assign taken = ev_valid && ev_ready;

  a_r3_write_no_charge: assert property (@(posedge clk) disable iff (rst)
    (taken && (ev_op == 3'd2 || ev_op == 3'd0)) |=> ($stable(tot_one) && $stable(tot_zero)));

  a_r4_refresh_no_charge: assert property (@(posedge clk) disable iff (rst)
    (taken && ev_op == 3'd4) |=> ($stable(tot_one) && $stable(tot_zero) && $stable(line_valid)));

  a_r6_invalid_ignored: assert property (@(posedge clk) disable iff (rst)
    (taken && ev_op != 3'd0 && !line_valid[ev_line])
      |=> ($stable(tot_one) && $stable(tot_zero) && $stable(line_valid)));

  a_r7_sum_bounds: assert property (@(posedge clk) disable iff (rst)
    (tot_sum >= tot_one) && (tot_sum >= tot_zero));

  a_r8_cap_monotone: assert property (@(posedge clk) disable iff (rst)
    (!clr && !$past(rst)) |=> (cap_time >= $past(cap_time)));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr && !$past(rst)) |=> (tot_one >= $past(tot_one) && tot_zero >= $past(tot_zero)));

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tot_one == '0 && tot_zero == '0 && cap_time == '0 && line_valid == '0));
endmodule

bind vuln_tally vuln_tally_chk #(
  .LINES(LINES), .W(W), .ACC_W(ACC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_op(ev_op), .ev_line(ev_line), .tot_one(tot_one), .tot_zero(tot_zero),
  .tot_sum(tot_sum), .cap_time(cap_time), .line_valid(line_valid)
);

// File: tb/vuln_tally_tb.sv
module vuln_tally_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 8;
  localparam int BW = 16;
  localparam int BDUR = 4;
  localparam int RC_MAX = 255;
  localparam int BIG_W = 48;
  localparam int SMALL_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic ev_valid = 1'b0;
  logic [2:0] ev_op = '0;
  logic [2:0] ev_line = '0;
  logic [BW-1:0] ev_wdata = '0;
  logic rdy_b, rdy_s;
  logic [BIG_W-1:0] b_one, b_zero, b_sum, b_cap;
  logic [SMALL_W-1:0] s_one, s_zero, s_sum, s_cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  vuln_tally u_dut (
    .clk(clk), .rst(rst), .clr(clr), .ev_valid(ev_valid), .ev_ready(rdy_b),
    .ev_op(ev_op), .ev_line(ev_line), .ev_wdata(ev_wdata),
    .tot_one(b_one), .tot_zero(b_zero), .tot_sum(b_sum), .cap_time(b_cap)
  );

  vuln_tally #(.ACC_W(SMALL_W)) u_small (
    .clk(clk), .rst(rst), .clr(clr), .ev_valid(ev_valid), .ev_ready(rdy_s),
    .ev_op(ev_op), .ev_line(ev_line), .ev_wdata(ev_wdata),
    .tot_one(s_one), .tot_zero(s_zero), .tot_sum(s_sum), .cap_time(s_cap)
  );

  int checks = 0;
  int bad = 0;
  bit done = 0;

  bit          m_valid [BL];
  logic [BW-1:0] m_data [BL];
  longint      m_ts [BL];
  int          m_rc [BL];
  longint      e1 = 0, e0 = 0, ecap = 0, mt = 0;

  function automatic int pop(logic [BW-1:0] v);
    int n = 0;
    for (int i = 0; i < BW; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic longint satv(longint v, int w);
    longint m = (longint'(1) << w) - 1;
    return (v > m) ? m : v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " tot_one"},  longint'(b_one),  satv(e1, BIG_W));
    chk({tag, " tot_zero"}, longint'(b_zero), satv(e0, BIG_W));
    chk({tag, " tot_sum R7"}, longint'(b_sum), satv(e1 + e0, BIG_W));
    chk({tag, " cap_time R8"}, longint'(b_cap), satv(ecap, BIG_W));
    chk({tag, " small one R9"},  longint'(s_one),  satv(e1, SMALL_W));
    chk({tag, " small zero R9"}, longint'(s_zero), satv(e0, SMALL_W));
    chk({tag, " small sum R9"},  longint'(s_sum),  satv(e1 + e0, SMALL_W));
    chk({tag, " small cap R9"},  longint'(s_cap),  satv(ecap, SMALL_W));
  endtask

  // Called at a falling edge; drives, updates the model for the next rising edge, checks at the next falling edge.
  task automatic step(string tag, bit v, logic [2:0] op, int ln, logic [BW-1:0] wd, bit c);
    ev_valid = v; ev_op = op; ev_line = 3'(ln); ev_wdata = wd; clr = c;
    #1;
    chk({tag, " ev_ready R10 R11"}, longint'(rdy_b), c ? 0 : 1);
    if (c) begin
      e1 = 0; e0 = 0; ecap = 0;
      for (int i = 0; i < BL; i++) begin m_valid[i] = 0; m_rc[i] = 0; end
    end else begin
      for (int i = 0; i < BL; i++) ecap += m_valid[i] ? BW : 0;
      if (v) begin
        case (op)
          3'd0: begin m_valid[ln] = 1; m_data[ln] = wd; m_ts[ln] = mt; m_rc[ln] = 0; end
          3'd1, 3'd3: if (m_valid[ln]) begin
            e1 += longint'(pop(m_data[ln])) * (mt - m_ts[ln]);
            e0 += longint'(BW - pop(m_data[ln])) * m_rc[ln] * BDUR;
            m_ts[ln] = mt; m_rc[ln] = 0;
            if (op == 3'd3) m_valid[ln] = 0;
          end
          3'd2: if (m_valid[ln]) begin m_data[ln] = wd; m_ts[ln] = mt; m_rc[ln] = 0; end
          3'd4: for (int i = 0; i < BL; i++)
                  if (m_valid[i] && m_rc[i] < RC_MAX) m_rc[i]++;
          default: ;
        endcase
      end
    end
    mt++;
    @(negedge clk);
    ev_valid = 0; clr = 0;
    chk_all(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("idle", 0, 3'd0, 0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired R11 act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    for (int i = 0; i < BL; i++) begin m_valid[i] = 0; m_rc[i] = 0; m_ts[i] = 0; m_data[i] = '0; end
    // R12: reset state
    chk("R12 reset one", longint'(b_one), 0);
    chk("R12 reset cap", longint'(b_cap), 0);

    // R1: all-ones word, 10 idle cycles then read: 16 * 11 = 176
    step("R10 clear", 0, 3'd0, 0, '0, 1);
    step("R1 fill", 1, 3'd0, 0, 16'hFFFF, 0);
    idle(10);
    step("R1 read", 1, 3'd1, 0, '0, 0);
    chk("R1 hand value", longint'(b_one), 176);

    // R2: all-zeros word, three refreshes: 16 * 3 * 4 = 192
    step("R10 clear", 0, 3'd0, 0, '0, 1);
    step("R2 fill", 1, 3'd0, 1, 16'h0000, 0);
    for (int i = 0; i < 3; i++) step("R4 refresh", 1, 3'd4, 5, '0, 0);
    step("R2 read", 1, 3'd1, 1, '0, 0);
    chk("R2 hand value", longint'(b_zero), 192);
    chk("R5 no leftover", longint'(b_one), 0);
    step("R5 reread", 1, 3'd1, 1, '0, 0);
    chk("R5 count restarted", longint'(b_zero), 192);

    // R3: write closes without charge, new word used afterwards
    step("R10 clear", 0, 3'd0, 0, '0, 1);
    step("R3 fill", 1, 3'd0, 2, 16'h00FF, 0);
    idle(5);
    step("R3 write", 1, 3'd2, 2, 16'hF000, 0);
    chk("R3 write no charge", longint'(b_sum), 0);
    idle(3);
    step("R3 read new word", 1, 3'd1, 2, '0, 0);
    chk("R3 new word charge", longint'(b_one), 4 * 4);

    // R6: events on invalid lines and unused op codes
    step("R10 clear", 0, 3'd0, 0, '0, 1);
    step("R6 read invalid", 1, 3'd1, 3, '0, 0);
    step("R6 write invalid", 1, 3'd2, 3, 16'hFFFF, 0);
    step("R6 evict invalid", 1, 3'd3, 3, '0, 0);
    step("R6 bad op", 1, 3'd6, 3, '0, 0);
    chk("R6 cap unchanged", longint'(b_cap), 0);
    step("R6 fill", 1, 3'd0, 3, 16'hFFFF, 0);
    step("R6 evict", 1, 3'd3, 3, '0, 0);
    step("R6 read after evict", 1, 3'd1, 3, '0, 0);
    chk("R6 no charge after evict", longint'(b_one), 16);

    // R9: fill all lines with ones, saturate the narrow instance
    step("R10 clear", 0, 3'd0, 0, '0, 1);
    for (int i = 0; i < BL; i++) step("R9 fill", 1, 3'd0, i, 16'hFFFF, 0);
    idle(40);
    chk("R9 cap saturates", longint'(s_cap), 4095);
    step("R9 read", 1, 3'd1, 0, '0, 0);
    idle(300);
    step("R9 read", 1, 3'd1, 0, '0, 0);
    chk("R9 one saturates", longint'(s_one), 4095);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 199));
      int ln = int'($urandom_range(0, BL - 1));
      logic [BW-1:0] wd = BW'($urandom);
      if (r < 1)        step("R10 rnd clear", 0, 3'd0, 0, '0, 1);
      else if (r < 30)  step("R3 rnd fill", 1, 3'd0, ln, wd, 0);
      else if (r < 90)  step("R1 R2 rnd read", 1, 3'd1, ln, '0, 0);
      else if (r < 125) step("R3 rnd write", 1, 3'd2, ln, wd, 0);
      else if (r < 145) step("R6 rnd evict", 1, 3'd3, ln, '0, 0);
      else if (r < 175) step("R4 rnd refresh", 1, 3'd4, ln, '0, 0);
      else if (r < 180) step("R6 rnd bad op", 1, 3'd7, ln, wd, 0);
      else              step("R8 rnd idle", 0, 3'd1, ln, wd, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule